// File: doc/BRIEF.md
# Five-Port Mesh Router with Dimension-Ordered Routing

This block forwards packets through one node of a two-dimensional on-chip mesh. It has four neighbour links (east, west, north, south) and one link to the node's own agent. Every link has a flit input with a valid strobe, a flit output with a valid strobe, and a credit wire in each direction. A packet is a head flit followed by zero or more body flits and a tail flit. A head flit that also carries the tail mark is a one-flit packet.

Each input stores arriving flits in a four-entry FIFO. When a head flit reaches the front of a FIFO, its destination coordinates choose an output. The packet resolves its X offset first and then its Y offset, so a packet never turns from Y back into X. Every output has its own controller with two states, `OUT_IDLE` and `OUT_LOCKED`. In `OUT_IDLE` it picks one requesting head flit by round robin (transition *grant*). In `OUT_LOCKED` it forwards that input's flits while it holds a downstream credit. When the tail flit leaves it returns to `OUT_IDLE` (transition *release*). An output stays in `OUT_LOCKED` and sends nothing while it has no credits or while its owner's FIFO is empty (transition *stall*).

The node's coordinates and the mesh size are parameters. Links that would face off the mesh edge are tied off.

Top module: `mesh_router`

## Requirements
- R1: Port index 0 is the local agent, 1 is east (X+1), 2 is west (X-1), 3 is north (Y+1) and 4 is south (Y-1). A packet leaves on exactly one output.
- R2: Bit FLIT_W-1 of a flit marks a head and bit FLIT_W-2 marks a tail. A head flit carries the destination X in bits [FLIT_W-3 -: COORD_W] and the destination Y in the COORD_W bits directly below those. The router does not look at the remaining bits, which hold source ID, command and address.
- R3: If the destination X is greater than the node's X, the packet leaves east. If it is smaller, the packet leaves west.
- R4: If the destination X equals the node's X, the packet leaves north when the destination Y is greater and south when it is smaller. A packet going out north or south never has a differing X.
- R5: If both coordinates equal the node's own, the packet leaves on the local port.
- R6: The output is chosen on the head flit only. All flits of a packet leave that output in order, and no flit of another packet appears on that output in between.
- R7: When several heads compete for one output, the input that follows the previous owner in index order wins. After reset the search starts at index 0.
- R8: Each output holds a credit count that starts at DEPTH. Sending a flit uses one credit and each tx_credit_ret pulse restores one. An output never drives tx_valid when it has no credits.
- R9: An input sends one rx_credit pulse for each flit that leaves its FIFO, and none for a flit that is still waiting.
- R10: A link facing off the mesh never drives tx_valid or rx_credit, and flits presented on it are dropped.
- R11: During reset and in the first cycle after reset, tx_valid and rx_credit are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 5 | Flit present on each input link |
| rx_flit | input | 5*FLIT_W | Input flits; link p uses slice [p*FLIT_W +: FLIT_W] |
| rx_credit | output | 5 | Credit pulse sent upstream on each input link |
| tx_valid | output | 5 | Flit present on each output link |
| tx_flit | output | 5*FLIT_W | Output flits, same slicing as rx_flit |
| tx_credit_ret | input | 5 | Credit pulse returned by the downstream node of each output |

## Verification
A corrupted credit count shows at the ports in one of two ways. Either a fifth unreturned flit appears on an output, or an output stays silent after credits have come back. A wrong owner or a wrong lock state shows within one flit, as a foreign flit inside a packet on an output or as a packet that comes out on the wrong link. A broken round-robin pointer shows only when two packets compete for an output, as a different order of whole packets on that output. For this reason the bench queues two packets on each of two inputs, so that round robin and fixed priority would produce different orders.

// File: rtl/mesh_pkg.sv
package mesh_pkg;
    localparam int NPORT = 5;

    typedef enum logic [2:0] {
        P_LOCAL = 3'd0,
        P_EAST  = 3'd1,
        P_WEST  = 3'd2,
        P_NORTH = 3'd3,
        P_SOUTH = 3'd4
    } port_e;

    typedef enum logic {
        OUT_IDLE,
        OUT_LOCKED
    } ostate_e;
endpackage

// File: rtl/flit_fifo.sv
module flit_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] front,
    output logic         empty,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          wr, rd;

    assign empty = (cnt == '0);
    assign full  = (cnt == CW'(DEPTH));
    assign wr    = push && !full;
    assign rd    = pop && !empty;
    assign front = mem[rp];

    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(wr) - CW'(rd);
        end
    end
endmodule

// File: rtl/xy_route.sv
module xy_route
    import mesh_pkg::*;
#(
    parameter int COORD_W = 2,
    parameter int X_POS   = 1,
    parameter int Y_POS   = 1
) (
    input  logic [COORD_W-1:0] dst_x,
    input  logic [COORD_W-1:0] dst_y,
    output port_e              dir
);
    localparam logic [COORD_W-1:0] MY_X = COORD_W'(X_POS);
    localparam logic [COORD_W-1:0] MY_Y = COORD_W'(Y_POS);

    always_comb begin
        if (dst_x > MY_X)      dir = P_EAST;
        else if (dst_x < MY_X) dir = P_WEST;
        else if (dst_y > MY_Y) dir = P_NORTH;
        else if (dst_y < MY_Y) dir = P_SOUTH;
        else                   dir = P_LOCAL;
    end
endmodule

// File: rtl/out_ctrl.sv
module out_ctrl
    import mesh_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPORT-1:0] req,
    input  logic [NPORT-1:0] src_empty,
    input  logic [NPORT-1:0] src_tail,
    input  logic             credit_ret,
    output logic             send,
    output logic [2:0]       owner
);
    localparam int CW = $clog2(DEPTH + 1);

    ostate_e       state, state_nx;
    logic [2:0]    owner_q, ptr_q, pick;
    logic          any_req;
    logic [CW-1:0] credits;
    logic          can_send;

    // round-robin search starting after the previous owner
    always_comb begin
        pick    = '0;
        any_req = 1'b0;
        for (int k = 1; k <= NPORT; k++) begin
            int idx;
            idx = int'(ptr_q) + k;
            if (idx >= NPORT) idx = idx - NPORT;
            if (!any_req && req[idx]) begin
                any_req = 1'b1;
                pick    = 3'(idx);
            end
        end
    end

    assign can_send = (state == OUT_LOCKED) && !src_empty[owner_q] && (credits != '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            OUT_IDLE:   if (any_req) state_nx = OUT_LOCKED;
            OUT_LOCKED: if (can_send && src_tail[owner_q]) state_nx = OUT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= OUT_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= '0;
            ptr_q   <= 3'(NPORT - 1);
        end else begin
            if (state == OUT_IDLE && any_req) owner_q <= pick;
            if (can_send && src_tail[owner_q]) ptr_q <= owner_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) credits <= CW'(DEPTH);
        else        credits <= credits - CW'(can_send) + CW'(credit_ret);
    end

    always_comb begin
        send  = can_send;
        owner = owner_q;
    end
endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import mesh_pkg::*;
#(
    parameter int FLIT_W  = 32,
    parameter int COORD_W = 2,
    parameter int MESH_W  = 4,
    parameter int MESH_H  = 4,
    parameter int X_POS   = 1,
    parameter int Y_POS   = 1,
    parameter int DEPTH   = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [4:0]              rx_valid,
    input  logic [5*FLIT_W-1:0]     rx_flit,
    output logic [4:0]              rx_credit,
    output logic [4:0]              tx_valid,
    output logic [5*FLIT_W-1:0]     tx_flit,
    input  logic [4:0]              tx_credit_ret
);
    localparam int DX_HI = FLIT_W - 3;
    localparam int DY_HI = FLIT_W - 3 - COORD_W;
    localparam logic [NPORT-1:0] LIVE = {
        (Y_POS > 0), (Y_POS < MESH_H - 1), (X_POS > 0), (X_POS < MESH_W - 1), 1'b1
    };

    logic [FLIT_W-1:0] front [NPORT];
    logic [NPORT-1:0]  empty, full, pop, is_head, is_tail;
    port_e             route [NPORT];
    logic [NPORT-1:0]  req_to [NPORT];
    logic [NPORT-1:0]  send;
    logic [2:0]        owner [NPORT];

    genvar g;
    for (g = 0; g < NPORT; g++) begin : g_in
        flit_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (rx_valid[g] && LIVE[g]),
            .din   (rx_flit[g*FLIT_W +: FLIT_W]),
            .pop   (pop[g]),
            .front (front[g]),
            .empty (empty[g]),
            .full  (full[g])
        );
        xy_route #(.COORD_W(COORD_W), .X_POS(X_POS), .Y_POS(Y_POS)) u_route (
            .dst_x (front[g][DX_HI -: COORD_W]),
            .dst_y (front[g][DY_HI -: COORD_W]),
            .dir   (route[g])
        );
        assign is_head[g] = front[g][FLIT_W-1];
        assign is_tail[g] = front[g][FLIT_W-2];
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                req_to[o][i] = LIVE[i] && LIVE[o] && !empty[i] && is_head[i]
                               && (route[i] == port_e'(o));
            end
        end
    end

    for (g = 0; g < NPORT; g++) begin : g_out
        if (LIVE[g]) begin : g_live
            out_ctrl #(.DEPTH(DEPTH)) u_ctrl (
                .clk        (clk),
                .rst_n      (rst_n),
                .req        (req_to[g]),
                .src_empty  (empty),
                .src_tail   (is_tail),
                .credit_ret (tx_credit_ret[g]),
                .send       (send[g]),
                .owner      (owner[g])
            );
        end else begin : g_tied
            assign send[g]  = 1'b0;
            assign owner[g] = '0;
        end
        assign tx_valid[g]                 = send[g];
        assign tx_flit[g*FLIT_W +: FLIT_W] = front[owner[g]];
    end

    always_comb begin
        pop = '0;
        for (int o = 0; o < NPORT; o++) begin
            if (send[o]) pop[owner[o]] = 1'b1;
        end
    end

    assign rx_credit = pop;
endmodule

// File: rtl/router_checker.sv
module router_checker #(
    parameter int FLIT_W  = 32,
    parameter int COORD_W = 2,
    parameter int MESH_W  = 4,
    parameter int MESH_H  = 4,
    parameter int X_POS   = 1,
    parameter int Y_POS   = 1,
    parameter int DEPTH   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [4:0]          rx_valid,
    input logic [4:0]          rx_credit,
    input logic [4:0]          tx_valid,
    input logic [5*FLIT_W-1:0] tx_flit,
    input logic [4:0]          tx_credit_ret
);
    localparam int CW = $clog2(DEPTH + 1) + 1;
    localparam logic [4:0] ALIVE = {
        (Y_POS > 0), (Y_POS < MESH_H - 1), (X_POS > 0), (X_POS < MESH_W - 1), 1'b1
    };
    localparam logic [COORD_W-1:0] MX = COORD_W'(X_POS);
    localparam logic [COORD_W-1:0] MY = COORD_W'(Y_POS);

    genvar g;
    for (g = 0; g < 5; g++) begin : g_chk
        logic [CW-1:0]      avail, occ;
        logic               mid;
        logic               hd, tl;
        logic [COORD_W-1:0] dx, dy;

        assign hd = tx_flit[g*FLIT_W + FLIT_W - 1];
        assign tl = tx_flit[g*FLIT_W + FLIT_W - 2];
        assign dx = tx_flit[g*FLIT_W + FLIT_W - 3 -: COORD_W];
        assign dy = tx_flit[g*FLIT_W + FLIT_W - 3 - COORD_W -: COORD_W];

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                avail <= CW'(DEPTH);
                occ   <= '0;
                mid   <= 1'b0;
            end else begin
                avail <= avail - CW'(tx_valid[g]) + CW'(tx_credit_ret[g]);
                occ   <= occ + CW'(rx_valid[g] && ALIVE[g]) - CW'(rx_credit[g]);
                if (tx_valid[g]) mid <= !tl;
            end
        end

        assert_credit_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid[g] |-> (avail != '0));

        assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_valid[g] && ALIVE[g]) |-> (occ < CW'(DEPTH)) || rx_credit[g]);

        assert_credit_backed_R9: assert property (@(posedge clk) disable iff (!rst_n)
            rx_credit[g] |-> (occ != '0));

        assert_packet_whole_R6: assert property (@(posedge clk) disable iff (!rst_n)
            tx_valid[g] |-> (hd == !mid));

        if (!ALIVE[g]) begin : g_dead
            assert_edge_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !tx_valid[g] && !rx_credit[g]);
        end

        if (g == 1) begin : g_e
            assert_east_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid[g] && hd) |-> (dx > MX));
        end
        if (g == 2) begin : g_w
            assert_west_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid[g] && hd) |-> (dx < MX));
        end
        if (g == 3) begin : g_n
            assert_north_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid[g] && hd) |-> (dx == MX && dy > MY));
        end
        if (g == 4) begin : g_s
            assert_south_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid[g] && hd) |-> (dx == MX && dy < MY));
        end
        if (g == 0) begin : g_l
            assert_local_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid[g] && hd) |-> (dx == MX && dy == MY));
        end
    end
endmodule

bind mesh_router router_checker #(
    .FLIT_W(FLIT_W), .COORD_W(COORD_W), .MESH_W(MESH_W), .MESH_H(MESH_H),
    .X_POS(X_POS), .Y_POS(Y_POS), .DEPTH(DEPTH)
) u_router_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_valid      (rx_valid),
    .rx_credit     (rx_credit),
    .tx_valid      (tx_valid),
    .tx_flit       (tx_flit),
    .tx_credit_ret (tx_credit_ret)
);

// File: tb/tb_mesh_router.sv
module tb_mesh_router;
    localparam int FW = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   rx_valid = '0, rx_credit, tx_valid, tx_cr, auto_ret = '0, man_ret = '0;
    logic [159:0] rx_flit = '0, tx_flit;
    logic [4:0]   e_rx_valid = '0, e_rx_credit, e_tx_valid, e_auto = '0;
    logic [159:0] e_rx_flit = '0, e_tx_flit;
    logic         hold = 1'b0;
    logic         done = 1'b0;

    logic [31:0]  cap [5][256];
    int           cap_n [5];
    int           cr_n [5];
    int           e_cap_n [5];
    int           e_cr_n [5];
    int           n_chk = 0, n_fail = 0;

    assign tx_cr = auto_ret | man_ret;

    always #5 clk = ~clk;

    mesh_router #(.FLIT_W(FW), .COORD_W(2), .MESH_W(3), .MESH_H(3),
                  .X_POS(1), .Y_POS(1), .DEPTH(4)) dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_flit(rx_flit),
        .rx_credit(rx_credit), .tx_valid(tx_valid), .tx_flit(tx_flit),
        .tx_credit_ret(tx_cr));

    mesh_router #(.FLIT_W(FW), .COORD_W(2), .MESH_W(3), .MESH_H(3),
                  .X_POS(2), .Y_POS(2), .DEPTH(4)) dut_edge (
        .clk(clk), .rst_n(rst_n), .rx_valid(e_rx_valid), .rx_flit(e_rx_flit),
        .rx_credit(e_rx_credit), .tx_valid(e_tx_valid), .tx_flit(e_tx_flit),
        .tx_credit_ret(e_auto));

    initial begin
        for (int p = 0; p < 5; p++) begin
            cap_n[p] = 0; cr_n[p] = 0; e_cap_n[p] = 0; e_cr_n[p] = 0;
        end
    end

    always @(negedge clk) begin
        for (int o = 0; o < 5; o++) begin
            if (tx_valid[o]) begin
                if (cap_n[o] < 256) cap[o][cap_n[o]] = tx_flit[o*FW +: FW];
                cap_n[o]++;
            end
            auto_ret[o] = tx_valid[o] && !hold;
            if (rx_credit[o]) cr_n[o]++;
            e_auto[o] = e_tx_valid[o];
            if (e_tx_valid[o]) e_cap_n[o]++;
            if (e_rx_credit[o]) e_cr_n[o]++;
        end
    end

    function automatic logic [31:0] mk(input bit hd, input bit tl, input int dx,
                                       input int dy, input int tag, input int idx);
        return {hd, tl, 2'(dx), 2'(dy), 10'd0, 8'(tag), 8'(idx)};
    endfunction

    function automatic int exp_port(input int mx, input int my, input int dx, input int dy);
        if (dx > mx) return 1;
        if (dx < mx) return 2;
        if (dy > my) return 3;
        if (dy < my) return 4;
        return 0;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic send_pkt(input int p, input int n, input int dx, input int dy, input int tag);
        for (int f = 0; f < n; f++) begin
            @(negedge clk);
            rx_valid[p] = 1'b1;
            rx_flit[p*FW +: FW] = mk(f == 0, f == n - 1, dx, dy, tag, f);
        end
        @(negedge clk);
        rx_valid[p] = 1'b0;
    endtask

    task automatic send_two(input int p, input int tag_a, input int tag_b);
        for (int f = 0; f < 4; f++) begin
            @(negedge clk);
            rx_valid[p] = 1'b1;
            rx_flit[p*FW +: FW] = mk(f % 2 == 0, f % 2 == 1, 1, 1, (f < 2) ? tag_a : tag_b, f % 2);
        end
        @(negedge clk);
        rx_valid[p] = 1'b0;
    endtask

    task automatic e_send(input int p, input int dx, input int dy, input int tag);
        for (int f = 0; f < 2; f++) begin
            @(negedge clk);
            e_rx_valid[p] = 1'b1;
            e_rx_flit[p*FW +: FW] = mk(f == 0, f == 1, dx, dy, tag, f);
        end
        @(negedge clk);
        e_rx_valid[p] = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int b0 [5];
        int c0 [5];
        do_reset();
        // R11: quiet outputs right after reset
        chk(tx_valid == 0 && rx_credit == 0, "R11", "tx_valid/rx_credit after reset",
            {tx_valid, rx_credit}, 0);
        chk(e_tx_valid == 0 && e_rx_credit == 0, "R11", "edge outputs after reset",
            {e_tx_valid, e_rx_credit}, 0);

        // Sweep: every input, every destination of the 3x3 mesh, 3-flit packets
        for (int i = 0; i < 5; i++) begin
            for (int dx = 0; dx < 3; dx++) begin
                for (int dy = 0; dy < 3; dy++) begin
                    int e, tag;
                    string rq;
                    e   = exp_port(1, 1, dx, dy);
                    tag = i * 9 + dx * 3 + dy;
                    rq  = (dx != 1) ? "R3" : ((dy != 1) ? "R4" : "R5");
                    for (int p = 0; p < 5; p++) begin b0[p] = cap_n[p]; c0[p] = cr_n[p]; end
                    send_pkt(i, 3, dx, dy, tag);
                    repeat (10) @(negedge clk);
                    chk(cap_n[e] - b0[e] == 3, rq, "flit count on routed port", cap_n[e] - b0[e], 3);
                    for (int f = 0; f < 3; f++)
                        chk(cap[e][b0[e] + f] == mk(f == 0, f == 2, dx, dy, tag, f), "R2",
                            "flit content/order", cap[e][b0[e] + f], mk(f == 0, f == 2, dx, dy, tag, f));
                    for (int p = 0; p < 5; p++)
                        if (p != e) chk(cap_n[p] == b0[p], "R1", "stray flits on other port",
                                        cap_n[p] - b0[p], 0);
                    chk(cr_n[i] - c0[i] == 3, "R9", "credit pulses upstream", cr_n[i] - c0[i], 3);
                end
            end
        end

        // R7/R6: two inputs queue two packets each for the local output
        do_reset();
        for (int p = 0; p < 5; p++) b0[p] = cap_n[p];
        fork
            send_two(1, 8'hA1, 8'hB1);
            send_two(2, 8'hA2, 8'hB2);
        join
        repeat (20) @(negedge clk);
        chk(cap_n[0] - b0[0] == 8, "R7", "local flit count in contention", cap_n[0] - b0[0], 8);
        begin
            int order [4] = '{8'hA1, 8'hA2, 8'hB1, 8'hB2};
            for (int k = 0; k < 8; k++)
                chk(cap[0][b0[0] + k][15:8] == 8'(order[k / 2]), "R7", "round-robin packet order",
                    cap[0][b0[0] + k][15:8], order[k / 2]);
            for (int k = 0; k < 8; k++)
                chk(cap[0][b0[0] + k][31:30] == ((k % 2 == 0) ? 2'b10 : 2'b01), "R6",
                    "packets not interleaved", cap[0][b0[0] + k][31:30], (k % 2 == 0) ? 2 : 1);
        end

        // R8: credit starvation on the local output
        do_reset();
        hold = 1'b1;
        for (int p = 0; p < 5; p++) begin b0[p] = cap_n[p]; c0[p] = cr_n[p]; end
        fork
            send_pkt(1, 4, 1, 1, 8'hC1);
            send_pkt(2, 2, 1, 1, 8'hC2);
        join
        repeat (15) @(negedge clk);
        chk(cap_n[0] - b0[0] == 4, "R8", "flits sent with no credit return", cap_n[0] - b0[0], 4);
        chk(cr_n[2] - c0[2] == 0, "R9", "no credit for waiting flits", cr_n[2] - c0[2], 0);
        man_ret[0] = 1'b1;
        @(negedge clk);
        man_ret[0] = 1'b0;
        repeat (5) @(negedge clk);
        chk(cap_n[0] - b0[0] == 5, "R8", "one flit per returned credit", cap_n[0] - b0[0], 5);
        chk(cap[0][b0[0] + 4] == mk(1, 0, 1, 1, 8'hC2, 0), "R6", "second packet head after first tail",
            cap[0][b0[0] + 4], mk(1, 0, 1, 1, 8'hC2, 0));
        hold = 1'b0;
        man_ret[0] = 1'b1;
        @(negedge clk);
        man_ret[0] = 1'b0;
        repeat (5) @(negedge clk);
        chk(cap_n[0] - b0[0] == 6, "R8", "flow resumes after credit", cap_n[0] - b0[0], 6);
        chk(cr_n[2] - c0[2] == 2, "R9", "credits after drain", cr_n[2] - c0[2], 2);

        // R10: corner node (2,2) of a 3x3 mesh, east and north face off the mesh
        for (int p = 0; p < 5; p++) begin b0[p] = e_cap_n[p]; c0[p] = e_cr_n[p]; end
        e_send(1, 2, 2, 8'hD1);
        repeat (10) @(negedge clk);
        chk(e_cap_n[0] == b0[0], "R10", "flit on dead input dropped", e_cap_n[0] - b0[0], 0);
        chk(e_cr_n[1] == c0[1], "R10", "no credit from dead input", e_cr_n[1] - c0[1], 0);
        e_send(0, 0, 2, 8'hD2);
        repeat (10) @(negedge clk);
        chk(e_cap_n[2] - b0[2] == 2, "R3", "edge node routes west", e_cap_n[2] - b0[2], 2);
        e_send(2, 2, 0, 8'hD3);
        repeat (10) @(negedge clk);
        chk(e_cap_n[4] - b0[4] == 2, "R4", "edge node routes south", e_cap_n[4] - b0[4], 2);
        chk(e_cap_n[1] == 0 && e_cap_n[3] == 0, "R10", "dead outputs silent",
            e_cap_n[1] + e_cap_n[3], 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule